// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer/Counter

This block is a 16-bit timer peripheral attached to a small register bus. A single 8-bit control byte chooses how the counter is clocked, what the counter does, and which interrupt requests are allowed to reach the CPU. The counter can be clocked in several ways: from one of four divided versions of the system clock, from the system clock directly, or from either edge of an external clock pin. The counter can also be frozen. The external clock pin and the capture pin pass through a synchronizer before their edges are detected.

The counter works in one of three modes:
- **Interval mode.** The counter runs up to a programmed compare value, returns to zero and toggles the timer output pin.
- **Capture mode.** The running count is latched on a chosen edge of the capture pin, while the counter keeps running.
- **PWM mode.** The counter runs freely over its full range, and the output is high while the count is below the compare value.

A wrap from all-ones to zero produces a one-cycle overflow request. Compare hits and captures set a sticky pending flag, which only software clears.

Register map (the `addr` input):

| Address | Register | Access |
|---|---|---|
| 0 | control byte | read/write |
| 1 | compare value | read/write |
| 2 | live count | read only |
| 3 | captured value | read only |
| 4 | status; bit 0 is the match/capture pending flag | read/write |

Reads are combinational. Writes take effect on the clock edge where `wr_en` is high.

Top module: `tmr16_multi`

## Requirements
- R1: After reset, these all read zero: the control byte, the count, the compare value, the status. The output `tmr_out`, `irq_ovf` and `irq_mc` are low.
- R2: The control byte bits 7:5 select the clock source. Codes 000, 001, 010, 011 and 100 advance the count once every 1024, 256, 64, 8 and 1 system clocks. Any write to the control byte restarts the divider, so after a write the count has gained floor(M/N) once M further clock edges have passed.
- R3: Clock code 101 advances the count on each falling edge of `ext_clk`, and code 110 on each rising edge. The count changes on the third clock edge after the pin changes. Code 111 holds the count.
- R4: A control write with bit 2 set makes the count zero on the next cycle, and bit 2 always reads back as 0. A control write with bit 2 clear leaves the count running.
- R5: Control bits 4:3 = 00 select interval mode. A counter tick taken while the count equals the compare value loads zero and toggles `tmr_out`, which gives a period of compare+1 ticks.
- R6: Mode 01 captures on a rising edge of `cap_in` and mode 10 on a falling edge. The count at the detect cycle is latched into the capture register on the third clock edge after the pin changes. The opposite edge is ignored, and the counter keeps running.
- R7: Mode 11 (PWM) counts freely, and `tmr_out` is high exactly while count < compare.
- R8: A tick at count FFFFh wraps to zero. If control bit 0 is set, `irq_ovf` is high for exactly one cycle, starting the edge of the wrap. If control bit 0 is clear, `irq_ovf` stays low.
- R9: A match or capture event sets status bit 0 whatever the enables are. Writing 0 to that bit clears it, writing 1 has no effect, and hardware never clears it. `irq_mc` equals the flag ANDed with control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the selected register |
| ext_clk | input | 1 | External count clock pin (asynchronous) |
| cap_in | input | 1 | Capture trigger pin (asynchronous) |
| tmr_out | output | 1 | Interval toggle or PWM output |
| irq_ovf | output | 1 | Overflow interrupt request pulse |
| irq_mc | output | 1 | Match/capture interrupt request level |

## Verification
The bench targets the following corner cases:
- **Divider phase after a control write.** A design that keeps the old phase would be off by one count in the divided modes.
- **Synchronizer latency of the external clock and capture pins.** A missing or extra stage shifts the captured value by one.
- **Interval wrap cycle.** An off-by-one comparator gives a period of compare or compare+2, not compare+1.
- **Overflow at FFFFh, with the enable on and with it off.** A wrong design gives a stuck or missing pulse, or a pulse while disabled.
- **The pending flag under both write values and while the interrupt is disabled.** A wrong design either loses a flag that only software may clear, or clears it on a write of 1.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

   typedef enum logic [1:0] {
      MODE_INTERVAL = 2'd0,
      MODE_CAP_RISE = 2'd1,
      MODE_CAP_FALL = 2'd2,
      MODE_PWM      = 2'd3
   } tmr_mode_e;

   typedef enum logic [2:0] {
      CK_DIV1024 = 3'd0,
      CK_DIV256  = 3'd1,
      CK_DIV64   = 3'd2,
      CK_DIV8    = 3'd3,
      CK_DIV1    = 3'd4,
      CK_EXT_FALL = 3'd5,
      CK_EXT_RISE = 3'd6,
      CK_STOP    = 3'd7
   } tmr_clk_e;

   localparam logic [2:0] RA_CTRL = 3'd0;
   localparam logic [2:0] RA_CMP  = 3'd1;
   localparam logic [2:0] RA_CNT  = 3'd2;
   localparam logic [2:0] RA_CAP  = 3'd3;
   localparam logic [2:0] RA_STAT = 3'd4;

   // log2 of the division ratio for the internal clock codes
   function automatic int div_shift(tmr_clk_e sel);
      case (sel)
         CK_DIV1024: return 10;
         CK_DIV256:  return 8;
         CK_DIV64:   return 6;
         CK_DIV8:    return 3;
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/tmr16_sync_edge.sv
module tmr16_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("tmr16_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise = sh_q[STAGES-1] & ~last_q;
   assign fall = ~sh_q[STAGES-1] & last_q;
endmodule

// File: rtl/tmr16_tick.sv
module tmr16_tick
   import tmr16_pkg::*;
#(
   parameter int PRE_W = 10
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     restart,
   input  tmr_clk_e sel,
   input  logic     ext_rise,
   input  logic     ext_fall,
   output logic     tick
);
   generate
      if (PRE_W < 10) begin : g_bad
         $error("tmr16_tick: PRE_W must cover the largest ratio (10 bits)");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) pre_q <= '0;
      else                   pre_q <= pre_q + PRE_W'(1);
   end

   always_comb begin
      mask = PRE_W'((1 << div_shift(sel)) - 1);
      case (sel)
         CK_EXT_FALL: tick = ext_fall;
         CK_EXT_RISE: tick = ext_rise;
         CK_STOP:     tick = 1'b0;
         default:     tick = ((pre_q & mask) == mask);
      endcase
   end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
   import tmr16_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   input  tmr_mode_e    mode,
   input  logic [W-1:0] cmp,
   input  logic         cap_rise,
   input  logic         cap_fall,
   output logic [W-1:0] cnt,
   output logic [W-1:0] cap,
   output logic         tog,
   output logic         ovf_ev,
   output logic         mc_ev
);
   logic hit, at_max, wrap_int, cap_ev;

   always_comb begin
      hit      = (cnt == cmp);
      at_max   = (cnt == {W{1'b1}});
      wrap_int = tick && (mode == MODE_INTERVAL) && hit;
      cap_ev   = ((mode == MODE_CAP_RISE) && cap_rise) ||
                 ((mode == MODE_CAP_FALL) && cap_fall);
      ovf_ev   = tick && at_max && !wrap_int;
      mc_ev    = cap_ev ||
                 (tick && hit && ((mode == MODE_INTERVAL) || (mode == MODE_PWM)));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         cap <= '0;
         tog <= 1'b0;
      end else begin
         if (clr)           cnt <= '0;
         else if (wrap_int) cnt <= '0;
         else if (tick)     cnt <= cnt + W'(1);
         if (wrap_int) tog <= ~tog;
         if (cap_ev)   cap <= cnt;
      end
   end
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
   import tmr16_pkg::*;
#(
   parameter int W     = 16,
   parameter int PRE_W = 10,
   parameter int SYNC  = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [2:0]   addr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   input  logic         ext_clk,
   input  logic         cap_in,
   output logic         tmr_out,
   output logic         irq_ovf,
   output logic         irq_mc
);
   generate
      if (W < 8) begin : g_bad
         $error("tmr16_multi: W must hold the 8-bit control byte");
      end
   endgenerate

   logic [7:0]   ctrl_q;
   logic [W-1:0] cmp_q;
   logic         pend_q;
   logic         ctrl_wr, clr, tick;
   logic         ext_rise, ext_fall, cap_rise, cap_fall;
   logic [W-1:0] cnt_q, cap_q;
   logic         tog, ovf_ev, mc_ev;
   tmr_mode_e    mode;
   tmr_clk_e     csel;

   assign ctrl_wr = wr_en && (addr == RA_CTRL);
   assign clr     = ctrl_wr && wdata[2];
   assign mode    = tmr_mode_e'(ctrl_q[4:3]);
   assign csel    = tmr_clk_e'(ctrl_q[7:5]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cmp_q   <= '0;
         pend_q  <= 1'b0;
         irq_ovf <= 1'b0;
      end else begin
         if (ctrl_wr) ctrl_q <= wdata[7:0] & 8'hFB;
         if (wr_en && addr == RA_CMP) cmp_q <= wdata;
         if (mc_ev) pend_q <= 1'b1;
         else if (wr_en && addr == RA_STAT && !wdata[0]) pend_q <= 1'b0;
         irq_ovf <= ovf_ev && ctrl_q[0];
      end
   end

   tmr16_sync_edge #(.STAGES(SYNC)) u_ext (
      .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(ext_rise), .fall(ext_fall));

   tmr16_sync_edge #(.STAGES(SYNC)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise(cap_rise), .fall(cap_fall));

   tmr16_tick #(.PRE_W(PRE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .restart(ctrl_wr), .sel(csel),
      .ext_rise(ext_rise), .ext_fall(ext_fall), .tick(tick));

   tmr16_core #(.W(W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr), .mode(mode),
      .cmp(cmp_q), .cap_rise(cap_rise), .cap_fall(cap_fall),
      .cnt(cnt_q), .cap(cap_q), .tog(tog), .ovf_ev(ovf_ev), .mc_ev(mc_ev));

   assign tmr_out = (mode == MODE_PWM) ? (cnt_q < cmp_q) : tog;
   assign irq_mc  = pend_q && ctrl_q[1];

   always_comb begin
      case (addr)
         RA_CTRL: rdata = W'(ctrl_q);
         RA_CMP:  rdata = cmp_q;
         RA_CNT:  rdata = cnt_q;
         RA_CAP:  rdata = cap_q;
         RA_STAT: rdata = W'(pend_q);
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [2:0]   addr,
   input logic [W-1:0] wdata,
   input logic         tmr_out,
   input logic         irq_ovf,
   input logic [W-1:0] cnt,
   input logic [7:0]   ctrl,
   input logic         pend
);
   // R4
   clear_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 3'd0 && wdata[2]) |=> (cnt == '0));

   // R8
   ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ovf |=> !irq_ovf);

   // R9
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !(wr_en && addr == 3'd4 && !wdata[0])) |=> pend);

   // R3
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[7:5] == 3'b111 && !(wr_en && addr == 3'd0)) |=> $stable(cnt));

   // R5
   toggle_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[4:3] == 2'b00 && $past(ctrl[4:3]) == 2'b00 && !$stable(tmr_out))
      |-> (cnt == '0));
endmodule

bind tmr16_multi tmr16_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .tmr_out(tmr_out), .irq_ovf(irq_ovf), .cnt(cnt_q), .ctrl(ctrl_q),
   .pend(pend_q));

// File: tb/sim_tmr16_multi.sv
module sim_tmr16_multi;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [15:0] wdata = 16'd0;
   logic [15:0] rdata;
   logic        ext_clk = 1'b0;
   logic        cap_in = 1'b0;
   logic        tmr_out, irq_ovf, irq_mc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   tmr16_multi u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .ext_clk(ext_clk), .cap_in(cap_in), .tmr_out(tmr_out),
      .irq_ovf(irq_ovf), .irq_mc(irq_mc));

   function automatic logic [15:0] mk(int ck, int md, bit clr, bit mce, bit ove);
      return 16'({ck[2:0], md[1:0], clr, mce, ove});
   endfunction

   function automatic int ratio(int ck);
      case (ck)
         0: return 1024;
         1: return 256;
         2: return 64;
         3: return 8;
         default: return 1;
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [2:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int v, v2, m, c, o0;
      void'($urandom(32'd4242));
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state
      rd(3'd0, v); chk("R1 ctrl", v, 0);
      rd(3'd2, v); chk("R1 count", v, 0);
      rd(3'd1, v); chk("R1 cmp", v, 0);
      rd(3'd4, v); chk("R1 status", v, 0);
      chk("R1 out", int'(tmr_out), 0);
      chk("R1 irq", int'(irq_ovf | irq_mc), 0);

      // R2 divider codes, random wait lengths
      wr(3'd1, 16'hFFFF);
      for (int ck = 0; ck < 5; ck++) begin
         for (int k = 0; k < 2; k++) begin
            m = $urandom_range(1, 2500);
            wr(3'd0, mk(ck, 0, 1, 0, 0));
            cyc(m);
            rd(3'd2, v);
            chk($sformatf("R2 code %0d", ck), v, m / ratio(ck));
         end
      end

      // R4 clear bit reads 0; write without clear keeps counting
      rd(3'd0, v); chk("R4 readback", v, int'(mk(4, 0, 0, 0, 0)));
      cyc(7);
      rd(3'd2, v);
      wr(3'd0, mk(4, 0, 0, 0, 0));
      rd(3'd2, v2); chk("R4 no clear", v2, v + 2);
      wr(3'd0, mk(4, 0, 1, 0, 0));
      rd(3'd2, v2); chk("R4 clear", v2, 0);

      // R3 external falling then rising edges, and stop
      wr(3'd0, mk(5, 0, 1, 0, 0));
      for (int p = 0; p < 4; p++) begin
         ext_clk = 1'b1; cyc(3); ext_clk = 1'b0; cyc(3);
      end
      cyc(4);
      rd(3'd2, v); chk("R3 falling", v, 4);
      wr(3'd0, mk(6, 0, 1, 0, 0));
      for (int p = 0; p < 5; p++) begin
         ext_clk = 1'b1; cyc(3); ext_clk = 1'b0; cyc(3);
      end
      cyc(4);
      rd(3'd2, v); chk("R3 rising", v, 5);
      wr(3'd0, mk(4, 0, 1, 0, 0));
      cyc(20);
      wr(3'd0, mk(7, 0, 0, 0, 0));
      rd(3'd2, v);
      ext_clk = 1'b1; cyc(20); ext_clk = 1'b0; cyc(20);
      rd(3'd2, v2); chk("R3 stop", v2, v);

      // R5 interval period compare+1
      for (int k = 0; k < 4; k++) begin
         c = $urandom_range(2, 40);
         wr(3'd1, 16'(c));
         wr(3'd0, mk(4, 0, 1, 0, 0));
         o0 = int'(tmr_out);
         cyc(c);
         rd(3'd2, v); chk("R5 count at compare", v, c);
         chk("R5 out before wrap", int'(tmr_out), o0);
         cyc(1);
         rd(3'd2, v); chk("R5 wrap to zero", v, 0);
         chk("R5 toggled", int'(tmr_out), 1 - o0);
         cyc(c + 1);
         chk("R5 toggled back", int'(tmr_out), o0);
      end

      // R9 pending flag
      wr(3'd0, mk(7, 0, 0, 0, 0));
      wr(3'd4, 16'h0000);
      rd(3'd4, v); chk("R9 cleared by 0", v, 0);
      wr(3'd1, 16'd3);
      wr(3'd0, mk(4, 0, 1, 0, 0));
      cyc(4);
      rd(3'd4, v); chk("R9 set while disabled", v, 1);
      chk("R9 irq masked", int'(irq_mc), 0);
      wr(3'd0, mk(7, 0, 0, 0, 0));
      wr(3'd4, 16'h0001);
      rd(3'd4, v); chk("R9 write 1 no effect", v, 1);
      wr(3'd0, mk(7, 0, 0, 1, 0));
      cyc(20);
      chk("R9 irq held", int'(irq_mc), 1);
      wr(3'd4, 16'h0000);
      rd(3'd4, v); chk("R9 clear", v, 0);
      chk("R9 irq drops", int'(irq_mc), 0);

      // R6 capture rising, random delays
      for (int k = 0; k < 3; k++) begin
         m = $urandom_range(5, 50);
         wr(3'd0, mk(4, 1, 1, 1, 0));
         cyc(m);
         cap_in = 1'b1;
         cyc(5);
         rd(3'd3, v); chk("R6 rise capture", v, m + 2);
         rd(3'd2, v); chk("R6 count runs", v, m + 5);
         cap_in = 1'b0;
         cyc(5);
         rd(3'd3, v); chk("R6 falling ignored", v, m + 2);
      end
      // R6 capture falling
      wr(3'd0, mk(4, 2, 1, 1, 0));
      cyc(1);
      cap_in = 1'b1;
      cyc(5);
      rd(3'd3, v2); chk("R6 rising ignored", v2, v);
      cap_in = 1'b0;
      cyc(5);
      rd(3'd3, v); chk("R6 fall capture", v, 8);
      rd(3'd4, v); chk("R6 pending", v, 1);

      // R7 PWM output
      for (int k = 0; k < 6; k++) begin
         c = (k == 0) ? 0 : $urandom_range(1, 400);
         m = $urandom_range(1, 600);
         wr(3'd1, 16'(c));
         wr(3'd0, mk(4, 3, 1, 0, 0));
         cyc(m);
         rd(3'd2, v); chk("R7 free run", v, m);
         chk("R7 out", int'(tmr_out), (m < c) ? 1 : 0);
      end

      // R8 overflow enabled then disabled
      wr(3'd1, 16'd100);
      wr(3'd0, mk(4, 3, 1, 0, 1));
      cyc(65535);
      rd(3'd2, v); chk("R8 at max", v, 65535);
      chk("R8 no early irq", int'(irq_ovf), 0);
      cyc(1);
      rd(3'd2, v); chk("R8 wrapped", v, 0);
      chk("R8 irq pulse", int'(irq_ovf), 1);
      cyc(1);
      chk("R8 pulse one cycle", int'(irq_ovf), 0);
      wr(3'd0, mk(4, 3, 1, 0, 0));
      cyc(65536);
      rd(3'd2, v); chk("R8 wrapped disabled", v, 0);
      chk("R8 irq disabled", int'(irq_ovf), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule